// File: doc/BRIEF.md
# Zero-Cross Detector Control Logic

This block is the digital side of a zero-cross detector. An analog comparator reports which side of zero a sensed signal is on. The block brings that raw result into the clock domain and applies an optional inversion. It raises a sticky interrupt flag on rising transitions, falling transitions or both. It also tells the pad when to take over the pin for current sourcing and sinking.

Software reaches the block through one 8-bit register on a simple register bus with address, write strobe and read data. The register holds an enable, a polarity select, two edge-interrupt enables and a live view of the detector output. A configuration-fuse input picks who controls the enable. With the fuse at 0 the detector is always on. With the fuse at 1 software turns it on and off with the enable bit. A dedicated strobe clears the interrupt flag.

Top module: `zcd_ctrl`

## Requirements
- R1: After reset the enable, polarity and both edge-enable bits are 0 and `irq_flag` is 0. With `fuse_cfg`=1 and `cmp_raw`=0, `pad_force` is 0 and the register reads 0x00.
- R2: Register fields are: bit 7 enable (read/write), bit 5 detector output (read-only), bit 4 polarity (read/write), bit 1 rising-edge interrupt enable, bit 0 falling-edge interrupt enable. Bits 6, 3 and 2 read 0. Writes to bits 6, 5, 3 and 2 have no effect.
- R3: The detector is active when `fuse_cfg`=0, whatever the enable bit holds. When `fuse_cfg`=1 it is active exactly when the enable bit is 1. `pad_force` equals the active state.
- R4: `cmp_raw` passes through a two-flop synchronizer. `det_out` shows a change of `cmp_raw` on the second rising clock edge after the change. While active, `det_out` is the synchronized value XOR the polarity bit. While inactive, `det_out` is 0.
- R5: With the rising-edge enable at 1, a 0-to-1 change of `det_out` sets `irq_flag` at the next clock edge. That is the third edge after a `cmp_raw` change.
- R6: With the falling-edge enable at 1, a 1-to-0 change of `det_out` sets `irq_flag` at the next clock edge. A transition whose direction enable is 0 leaves `irq_flag` unchanged.
- R7: No edge is reported while the detector is inactive. No edge is reported on the cycle it becomes active, even if `det_out` jumps to 1.
- R8: `irq_flag` holds until `flag_clr` is sampled high. If a set and `flag_clr` fall on the same edge, the flag ends at 1.
- R9: A write with `reg_addr` different from parameter `REG_ADDR` (default 2) changes nothing. Reads at any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_cfg | input | 1 | 0: detector always on; 1: software enable in control |
| cmp_raw | input | 1 | Asynchronous comparator result |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flag_clr | input | 1 | Clears the interrupt flag |
| det_out | output | 1 | Polarity-adjusted detector output |
| pad_force | output | 1 | Pad override for source/sink drive |
| irq_flag | output | 1 | Sticky zero-cross interrupt flag |

## Verification
The assertions assume that `fuse_cfg` and the register fields change only through synchronous inputs. They also assume that `flag_clr` is a clean level sampled at the clock edge. The bench drives every input, `cmp_raw` included, on the falling clock edge, so the synchronizer never sees a change at its sampling edge. Each scenario lets the comparator input settle for several cycles and clears the flag before it makes the transition under test. Changes of polarity or enable therefore cannot leave a stray edge that the next check would misread.

// File: rtl/zcd_pkg.sv
package zcd_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_DET  = 5;
  localparam int BIT_POL  = 4;
  localparam int BIT_IE_R = 1;
  localparam int BIT_IE_F = 0;

  function automatic logic pol_apply(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  function automatic logic rise_of(input logic cur, input logic prv, input logic ok);
    return ok & cur & ~prv;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prv, input logic ok);
    return ok & ~cur & prv;
  endfunction
endpackage

// File: rtl/zcd_sync.sv
module zcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/zcd_cfg_reg.sv
module zcd_cfg_reg
  import zcd_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              det,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              pol,
  output logic              ie_rise,
  output logic              ie_fall
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      pol     <= 1'b0;
      ie_rise <= 1'b0;
      ie_fall <= 1'b0;
    end else if (wr && hit) begin
      en      <= wdata[BIT_EN];
      pol     <= wdata[BIT_POL];
      ie_rise <= wdata[BIT_IE_R];
      ie_fall <= wdata[BIT_IE_F];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_EN]   = en;
      rdata[BIT_DET]  = det;
      rdata[BIT_POL]  = pol;
      rdata[BIT_IE_R] = ie_rise;
      rdata[BIT_IE_F] = ie_fall;
    end
  end
endmodule

// File: rtl/zcd_edge_flag.sv
module zcd_edge_flag
  import zcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic active,
  input  logic ie_rise,
  input  logic ie_fall,
  input  logic clr,
  output logic active_q,
  output logic rise_evt,
  output logic fall_evt,
  output logic set_evt,
  output logic flag
);
  logic prev;
  logic edge_ok;

  assign edge_ok  = active & active_q;
  assign rise_evt = rise_of(det, prev, edge_ok);
  assign fall_evt = fall_of(det, prev, edge_ok);
  assign set_evt  = (rise_evt & ie_rise) | (fall_evt & ie_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= 1'b0;
      active_q <= 1'b0;
      flag     <= 1'b0;
    end else begin
      prev     <= det;
      active_q <= active;
      flag     <= set_evt | (flag & ~clr);
    end
  end
endmodule

// File: rtl/zcd_ctrl.sv
module zcd_ctrl
  import zcd_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fuse_cfg,
  input  logic              cmp_raw,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              flag_clr,
  output logic              det_out,
  output logic              pad_force,
  output logic              irq_flag
);
  logic cmp_s, en, pol, ie_rise, ie_fall, active;
  logic active_q, rise_evt, fall_evt, set_evt;

  zcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_s)
  );

  zcd_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .det(det_out), .rdata(reg_rdata),
    .en(en), .pol(pol), .ie_rise(ie_rise), .ie_fall(ie_fall)
  );

  assign active    = ~fuse_cfg | en;
  assign pad_force = active;
  assign det_out   = active & pol_apply(cmp_s, pol);

  zcd_edge_flag u_edge (
    .clk(clk), .rst_n(rst_n), .det(det_out), .active(active),
    .ie_rise(ie_rise), .ie_fall(ie_fall), .clr(flag_clr),
    .active_q(active_q), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .set_evt(set_evt), .flag(irq_flag)
  );
endmodule

// File: rtl/zcd_ctrl_chk.sv
module zcd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fuse_cfg,
  input logic pad_force,
  input logic det_out,
  input logic irq_flag,
  input logic flag_clr,
  input logic active,
  input logic rise_evt,
  input logic fall_evt,
  input logic set_evt,
  input logic ie_rise,
  input logic ie_fall
);
  a_r3_fuse_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_cfg |-> pad_force);
  a_r4_idle_output_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_force |-> !det_out);
  a_r5_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && ie_rise) |=> irq_flag);
  a_r6_fall_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && ie_fall) |=> irq_flag);
  a_r7_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!rise_evt && !fall_evt));
  a_r7_no_edge_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (!rise_evt && !fall_evt));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_evt) |=> !irq_flag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq_flag);
endmodule

bind zcd_ctrl zcd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fuse_cfg(fuse_cfg), .pad_force(pad_force),
  .det_out(det_out), .irq_flag(irq_flag), .flag_clr(flag_clr),
  .active(active), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .set_evt(set_evt), .ie_rise(ie_rise), .ie_fall(ie_fall)
);

// File: tb/tb_zcd_ctrl.sv
module tb_zcd_ctrl;
  localparam logic [3:0] RA = 4'd2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fuse_cfg = 1'b1, cmp_raw = 1'b0, reg_wr = 1'b0, flag_clr = 1'b0;
  logic [3:0] reg_addr = RA;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic det_out, pad_force, irq_flag;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  zcd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fuse_cfg(fuse_cfg), .cmp_raw(cmp_raw),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flag_clr(flag_clr), .det_out(det_out),
    .pad_force(pad_force), .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0; reg_addr = RA;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = RA;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic settle(input logic level);
    cmp_raw = level; tick(4); clear_flag();
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rd_reg(RA, r);
    chk("R1 reg", r, 8'h00);
    chk("R1 pad", {7'd0, pad_force}, 8'd0);
    chk("R1 flag", {7'd0, irq_flag}, 8'd0);
  endtask

  task automatic t_fuse();
    logic [7:0] r;
    fuse_cfg = 1'b0; #1;
    chk("R3 pad fuse0", {7'd0, pad_force}, 8'd1);
    cmp_raw = 1'b1; tick(1);
    chk("R4 det one edge", {7'd0, det_out}, 8'd0);
    tick(1);
    chk("R4 det two edges", {7'd0, det_out}, 8'd1);
    rd_reg(RA, r);
    chk("R2 det bit", r, 8'h20);
    fuse_cfg = 1'b1; #1;
    chk("R3 pad fuse1", {7'd0, pad_force}, 8'd0);
    chk("R4 det idle", {7'd0, det_out}, 8'd0);
    cmp_raw = 1'b0; tick(3);
  endtask

  task automatic t_layout();
    logic [7:0] r;
    wr_reg(RA, 8'hFF);
    rd_reg(RA, r);
    chk("R2 all ones", r, 8'hB3);
    wr_reg(RA, 8'h6C);
    rd_reg(RA, r);
    chk("R2 reserved ignored", r, 8'h00);
  endtask

  task automatic t_addr();
    logic [7:0] r;
    wr_reg(RA, 8'h13);
    wr_reg(4'd5, 8'h80);
    rd_reg(RA, r);
    chk("R9 foreign write", r, 8'h13);
    rd_reg(4'd5, r);
    chk("R9 foreign read", r, 8'h00);
    wr_reg(RA, 8'h00);
  endtask

  task automatic t_rise();
    wr_reg(RA, 8'h82); settle(1'b0);
    cmp_raw = 1'b1; tick(2);
    chk("R5 not yet", {7'd0, irq_flag}, 8'd0);
    tick(1);
    chk("R5 rise sets", {7'd0, irq_flag}, 8'd1);
    tick(3);
    chk("R8 sticky", {7'd0, irq_flag}, 8'd1);
    clear_flag();
    chk("R8 cleared", {7'd0, irq_flag}, 8'd0);
    cmp_raw = 1'b0; tick(4);
    chk("R6 fall masked", {7'd0, irq_flag}, 8'd0);
  endtask

  task automatic t_fall();
    wr_reg(RA, 8'h81); settle(1'b1);
    cmp_raw = 1'b0; tick(3);
    chk("R6 fall sets", {7'd0, irq_flag}, 8'd1);
    clear_flag();
    cmp_raw = 1'b1; tick(4);
    chk("R5 rise masked", {7'd0, irq_flag}, 8'd0);
  endtask

  task automatic t_pol();
    wr_reg(RA, 8'h92); settle(1'b1);
    chk("R4 inverted", {7'd0, det_out}, 8'd0);
    cmp_raw = 1'b0; tick(3);
    chk("R4 pol before edge", {7'd0, irq_flag}, 8'd1);
    clear_flag();
  endtask

  task automatic t_enable();
    wr_reg(RA, 8'h03); settle(1'b0);
    cmp_raw = 1'b1; tick(4);
    chk("R7 idle no edge", {7'd0, irq_flag}, 8'd0);
    wr_reg(RA, 8'h83); tick(3);
    chk("R7 enable no edge", {7'd0, irq_flag}, 8'd0);
    chk("R3 det on", {7'd0, det_out}, 8'd1);
  endtask

  task automatic t_setwins();
    wr_reg(RA, 8'h82); settle(1'b0);
    cmp_raw = 1'b1; tick(2);
    flag_clr = 1'b1; tick(1);
    chk("R8 set wins", {7'd0, irq_flag}, 8'd1);
    tick(1); flag_clr = 1'b0;
    chk("R8 clear after", {7'd0, irq_flag}, 8'd0);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset(); t_fuse(); t_layout(); t_addr(); t_rise();
    t_fall(); t_pol(); t_enable(); t_setwins();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule